// File: doc/BRIEF.md
# Vector Shift-Round-Saturate Unit

This block converts data between the wide fixed-point accumulator format and the narrower vector register format. On the downshift path it takes eight signed 48-bit accumulator lanes, shifts each one right arithmetically by a programmable count, optionally rounds, optionally clamps, and returns eight signed 32-bit lanes. On the upshift path it takes eight signed 32-bit lanes, sign-extends each to 48 bits, and shifts it left into the accumulator layout. The 16 bits above the 32-bit product range act as guard bits, so sums can grow there without overflowing.

Two single-bit modes, rounding and saturation, are each turned on by a set pulse and off by a clear pulse. With both modes off, a downshift is a plain arithmetic shift truncated to 32 bits. Operations enter through a valid/ready handshake and leave from one output register. A per-lane flag reports each lane that the saturation logic clamped.

Top module: `vsrs_unit`

## Requirements
- R1: An operation is accepted on a rising edge where `in_valid` and `in_ready` are both high. Its result appears with `out_valid` high after that edge. `in_ready` is high whenever `out_valid` is low or `out_ready` is high. While `out_valid` is high and `out_ready` is low, all outputs hold steady.
- R2: `round_mode` and `sat_mode` go high one cycle after their set pulse and low one cycle after their clear pulse. If set and clear arrive in the same cycle, clear wins. An operation uses the mode values held before any command that arrives in the same cycle.
- R3: A downshift (`in_dir`=0) with both modes off gives floor(x / 2^s) for shift s from 0 to 47, keeping bits 31:0.
- R4: With rounding on, 2^(s-1) is added to the 48-bit lane before the right shift (round half up). A shift of 0 is not affected by rounding.
- R5: With saturation on, a shifted value above 2^31-1 becomes 0x7FFFFFFF and a value below -2^31 becomes 0x80000000. The lane's bit in `out_ovf` is set only when such a clamp happens.
- R6: With saturation off, the low 32 bits are kept even when the value wraps, and `out_ovf` is all zero.
- R7: For a downshift with s of 48 or more, the lane result is 0 for a non-negative input and 0xFFFFFFFF for a negative input, whatever the rounding mode.
- R8: An upshift (`in_dir`=1) sign-extends each 32-bit lane to 48 bits and shifts it left by s, discarding bits above bit 47. A shift of 48 or more gives 0. `out_vec` and `out_ovf` are zero for an upshift.
- R9: Lanes are independent. Lane i occupies bits [i*48 +: 48] of the accumulator buses, bits [i*32 +: 32] of the vector buses, and bit i of `out_ovf`. `out_dir` repeats the direction of the result.
- R10: After reset, `out_valid`, `round_mode` and `sat_mode` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_round_set | input | 1 | Turn rounding on |
| cfg_round_clr | input | 1 | Turn rounding off |
| cfg_sat_set | input | 1 | Turn saturation on |
| cfg_sat_clr | input | 1 | Turn saturation off |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken |
| in_dir | input | 1 | 0 = downshift, 1 = upshift |
| in_shift | input | 6 | Shift count |
| in_acc | input | 384 | Accumulator lanes for a downshift |
| in_vec | input | 256 | Vector lanes for an upshift |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Result taken |
| out_dir | output | 1 | Direction of the result |
| out_vec | output | 256 | Downshift result lanes |
| out_acc | output | 384 | Upshift result lanes |
| out_ovf | output | 8 | Per-lane clamp flag |
| round_mode | output | 1 | Current rounding mode |
| sat_mode | output | 1 | Current saturation mode |

## Verification
Every shift count from 0 to 63 is tried under all four mode combinations. Each test uses one lane set that holds the largest and smallest 48-bit values, plus and minus one and a half LSB, and a value that crosses into the positive clamp only when rounded, together with random lanes. This separates truncation from round half up on both signs, shows saturation against wrap, and covers the sign fill for oversized shifts. Upshift is swept the same way with the 32-bit extremes, which exposes sign extension and discarded top bits. Separate sequences stall the output, send set and clear in the same cycle, and send a mode change in the same cycle as an operation.

// File: rtl/vsrs_pkg.sv
package vsrs_pkg;
  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } dir_e;
endpackage

// File: rtl/vsrs_mode_bit.sv
module vsrs_mode_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic mode_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)      mode_o <= 1'b0;
    else if (clr_i)  mode_o <= 1'b0;
    else if (set_i)  mode_o <= 1'b1;
  end
endmodule

// File: rtl/vsrs_down_lane.sv
module vsrs_down_lane #(
  parameter int ACC_W   = 48,
  parameter int VEC_W   = 32,
  parameter int SHIFT_W = 6
) (
  input  logic [ACC_W-1:0]   acc_i,
  input  logic [SHIFT_W-1:0] shift_i,
  input  logic               round_en_i,
  input  logic               sat_en_i,
  output logic [VEC_W-1:0]   res_o,
  output logic               clip_o
);
  localparam int EXT_W = ACC_W + 1;
  localparam logic signed [EXT_W-1:0] VMAX =
    $signed((EXT_W'(1) << (VEC_W - 1)) - EXT_W'(1));
  localparam logic signed [EXT_W-1:0] VMIN = ~VMAX;

  function automatic logic signed [EXT_W-1:0] shift_round(
    input logic [ACC_W-1:0]   x,
    input logic [SHIFT_W-1:0] s,
    input logic               rnd
  );
    logic signed [EXT_W-1:0] e;
    e = $signed({x[ACC_W-1], x});
    if (s >= SHIFT_W'(ACC_W)) begin
      return x[ACC_W-1] ? '1 : '0;
    end
    if (rnd && (s != '0)) begin
      e = e + $signed(EXT_W'(1) << (s - SHIFT_W'(1)));
    end
    return e >>> s;
  endfunction

  logic signed [EXT_W-1:0] shifted;
  logic                    above_max;
  logic                    below_min;

  always_comb begin
    shifted   = shift_round(acc_i, shift_i, round_en_i);
    above_max = shifted > VMAX;
    below_min = shifted < VMIN;
    if (sat_en_i && above_max)      res_o = VMAX[VEC_W-1:0];
    else if (sat_en_i && below_min) res_o = VMIN[VEC_W-1:0];
    else                            res_o = shifted[VEC_W-1:0];
    clip_o = sat_en_i && (above_max || below_min);
  end
endmodule

// File: rtl/vsrs_up_lane.sv
module vsrs_up_lane #(
  parameter int ACC_W   = 48,
  parameter int VEC_W   = 32,
  parameter int SHIFT_W = 6
) (
  input  logic [VEC_W-1:0]   vec_i,
  input  logic [SHIFT_W-1:0] shift_i,
  output logic [ACC_W-1:0]   res_o
);
  localparam int PAD_W = ACC_W - VEC_W;

  function automatic logic [ACC_W-1:0] widen_shift(
    input logic [VEC_W-1:0]   v,
    input logic [SHIFT_W-1:0] s
  );
    logic [ACC_W-1:0] e;
    e = {{PAD_W{v[VEC_W-1]}}, v};
    return e << s;
  endfunction

  assign res_o = widen_shift(vec_i, shift_i);
endmodule

// File: rtl/vsrs_unit.sv
module vsrs_unit #(
  parameter int LANES   = 8,
  parameter int ACC_W   = 48,
  parameter int VEC_W   = 32,
  parameter int SHIFT_W = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_round_set,
  input  logic                     cfg_round_clr,
  input  logic                     cfg_sat_set,
  input  logic                     cfg_sat_clr,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic                     in_dir,
  input  logic [SHIFT_W-1:0]       in_shift,
  input  logic [LANES*ACC_W-1:0]   in_acc,
  input  logic [LANES*VEC_W-1:0]   in_vec,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic                     out_dir,
  output logic [LANES*VEC_W-1:0]   out_vec,
  output logic [LANES*ACC_W-1:0]   out_acc,
  output logic [LANES-1:0]         out_ovf,
  output logic                     round_mode,
  output logic                     sat_mode
);
  import vsrs_pkg::*;

  localparam int ACC_BUS = LANES * ACC_W;
  localparam int VEC_BUS = LANES * VEC_W;

  logic               accept;
  logic [VEC_BUS-1:0] down_vec;
  logic [LANES-1:0]   down_clip;
  logic [ACC_BUS-1:0] up_acc;
  dir_e               dir_in;

  assign dir_in   = dir_e'(in_dir);
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  vsrs_mode_bit u_round (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (cfg_round_set),
    .clr_i  (cfg_round_clr),
    .mode_o (round_mode)
  );

  vsrs_mode_bit u_sat (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (cfg_sat_set),
    .clr_i  (cfg_sat_clr),
    .mode_o (sat_mode)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    vsrs_down_lane #(
      .ACC_W   (ACC_W),
      .VEC_W   (VEC_W),
      .SHIFT_W (SHIFT_W)
    ) u_down (
      .acc_i      (in_acc[i*ACC_W +: ACC_W]),
      .shift_i    (in_shift),
      .round_en_i (round_mode),
      .sat_en_i   (sat_mode),
      .res_o      (down_vec[i*VEC_W +: VEC_W]),
      .clip_o     (down_clip[i])
    );

    vsrs_up_lane #(
      .ACC_W   (ACC_W),
      .VEC_W   (VEC_W),
      .SHIFT_W (SHIFT_W)
    ) u_up (
      .vec_i   (in_vec[i*VEC_W +: VEC_W]),
      .shift_i (in_shift),
      .res_o   (up_acc[i*ACC_W +: ACC_W])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_dir   <= 1'b0;
      out_vec   <= '0;
      out_acc   <= '0;
      out_ovf   <= '0;
    end else begin
      if (accept) begin
        out_valid <= 1'b1;
        out_dir   <= in_dir;
        if (dir_in == DIR_UP) begin
          out_vec <= '0;
          out_acc <= up_acc;
          out_ovf <= '0;
        end else begin
          out_vec <= down_vec;
          out_acc <= '0;
          out_ovf <= down_clip;
        end
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/vsrs_checker.sv
module vsrs_checker #(
  parameter int LANES = 8,
  parameter int ACC_W = 48,
  parameter int VEC_W = 32
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   accept,
  input logic                   cfg_round_set,
  input logic                   cfg_round_clr,
  input logic                   cfg_sat_set,
  input logic                   cfg_sat_clr,
  input logic                   out_valid,
  input logic                   out_ready,
  input logic                   out_dir,
  input logic [LANES*VEC_W-1:0] out_vec,
  input logic [LANES*ACC_W-1:0] out_acc,
  input logic [LANES-1:0]       out_ovf,
  input logic                   round_mode,
  input logic                   sat_mode
);
  localparam logic [VEC_W-1:0] LMAX = {1'b0, {(VEC_W-1){1'b1}}};
  localparam logic [VEC_W-1:0] LMIN = {1'b1, {(VEC_W-1){1'b0}}};

  assert_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !accept) |=>
      (out_valid && $stable(out_vec) && $stable(out_acc) && $stable(out_ovf)));

  assert_round_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_round_set && !cfg_round_clr) |=> round_mode);

  assert_round_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_round_clr |=> !round_mode);

  assert_sat_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_sat_set && !cfg_sat_clr) |=> sat_mode);

  assert_sat_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_sat_clr |=> !sat_mode);

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !sat_mode) |=> (out_ovf == '0));

  assert_up_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_dir) |-> ((out_ovf == '0) && (out_vec == '0)));

  for (genvar i = 0; i < LANES; i++) begin : g_chk
    assert_clamp_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ovf[i]) |->
        ((out_vec[i*VEC_W +: VEC_W] == LMAX) || (out_vec[i*VEC_W +: VEC_W] == LMIN)));
  end
endmodule

bind vsrs_unit vsrs_checker #(
  .LANES (LANES),
  .ACC_W (ACC_W),
  .VEC_W (VEC_W)
) u_vsrs_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .accept        (accept),
  .cfg_round_set (cfg_round_set),
  .cfg_round_clr (cfg_round_clr),
  .cfg_sat_set   (cfg_sat_set),
  .cfg_sat_clr   (cfg_sat_clr),
  .out_valid     (out_valid),
  .out_ready     (out_ready),
  .out_dir       (out_dir),
  .out_vec       (out_vec),
  .out_acc       (out_acc),
  .out_ovf       (out_ovf),
  .round_mode    (round_mode),
  .sat_mode      (sat_mode)
);

// File: tb/vsrs_unit_test.sv
`timescale 1ns/1ps
module vsrs_unit_test;
  localparam int L = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_round_set = 0, cfg_round_clr = 0, cfg_sat_set = 0, cfg_sat_clr = 0;
  logic in_valid = 0, in_dir = 0, out_ready = 1;
  logic in_ready, out_valid, out_dir, round_mode, sat_mode;
  logic [5:0] in_shift = '0;
  logic [L*48-1:0] in_acc = '0, out_acc;
  logic [L*32-1:0] in_vec = '0, out_vec;
  logic [L-1:0] out_ovf;

  int n_checks = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  vsrs_unit uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_round_set(cfg_round_set), .cfg_round_clr(cfg_round_clr),
    .cfg_sat_set(cfg_sat_set), .cfg_sat_clr(cfg_sat_clr),
    .in_valid(in_valid), .in_ready(in_ready), .in_dir(in_dir),
    .in_shift(in_shift), .in_acc(in_acc), .in_vec(in_vec),
    .out_valid(out_valid), .out_ready(out_ready), .out_dir(out_dir),
    .out_vec(out_vec), .out_acc(out_acc), .out_ovf(out_ovf),
    .round_mode(round_mode), .sat_mode(sat_mode)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [383:0] act, input logic [383:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Expected downshift: {clip, 32-bit result}
  function automatic logic [32:0] ref_down(longint x, int s, bit rnd, bit sat);
    longint v;
    if (s >= 48) v = (x < 0) ? -64'sd1 : 64'sd0;
    else begin
      v = x;
      if (rnd && s > 0) v = v + (64'sd1 <<< (s - 1));
      v = v >>> s;
    end
    if (sat && v > 64'sd2147483647) return {1'b1, 32'h7FFF_FFFF};
    if (sat && v < -64'sd2147483648) return {1'b1, 32'h8000_0000};
    return {1'b0, v[31:0]};
  endfunction

  function automatic logic [47:0] ref_up(longint x, int s);
    longint t;
    if (s >= 48) return 48'd0;
    t = x <<< s;
    return t[47:0];
  endfunction

  task automatic pulse_cfg(input bit rs, input bit rc, input bit ss, input bit sc);
    @(negedge clk);
    cfg_round_set = rs; cfg_round_clr = rc; cfg_sat_set = ss; cfg_sat_clr = sc;
    @(posedge clk);
    @(negedge clk);
    cfg_round_set = 0; cfg_round_clr = 0; cfg_sat_set = 0; cfg_sat_clr = 0;
  endtask

  task automatic set_modes(input bit rnd, input bit sat);
    pulse_cfg(rnd, !rnd, sat, !sat);
    check(round_mode == rnd && sat_mode == sat, "R2", "mode outputs",
          {round_mode, sat_mode}, {rnd, sat});
  endtask

  longint a [L];
  longint b [L];

  task automatic fill_acc();
    a[0] = 64'sd140737488355327;       // 2^47-1
    a[1] = -64'sd140737488355328;      // -2^47
    a[2] = $signed({$urandom, $urandom}) >>> 16;
    a[3] = longint'($urandom % 2000) - 1000;
    a[4] = 64'sd549755813760;          // 0x7F_FFFF_FF80
    a[5] = 64'sd384;                   // 1.5 at shift 8
    a[6] = -64'sd384;                  // -1.5 at shift 8
    a[7] = $signed({$urandom, $urandom}) >>> 30;
    for (int i = 0; i < L; i++) in_acc[i*48 +: 48] = a[i][47:0];
  endtask

  task automatic fill_vec();
    b[0] = 64'sd2147483647;
    b[1] = -64'sd2147483648;
    b[2] = 1;
    b[3] = -1;
    b[4] = longint'($signed($urandom));
    b[5] = longint'($signed($urandom));
    b[6] = 64'sd74565;
    b[7] = -7;
    for (int i = 0; i < L; i++) in_vec[i*32 +: 32] = b[i][31:0];
  endtask

  task automatic run_op(input bit dir, input int s);
    @(negedge clk);
    in_dir = dir; in_shift = 6'(s); in_valid = 1; out_ready = 1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic check_down(input int s, input bit rnd, input bit sat, input string req);
    logic [255:0] ev;
    logic [7:0] eo;
    logic [32:0] r;
    for (int i = 0; i < L; i++) begin
      r = ref_down(a[i], s, rnd, sat);
      ev[i*32 +: 32] = r[31:0];
      eo[i] = r[32];
    end
    check(out_valid && !out_dir && out_vec == ev && out_ovf == eo && out_acc == '0,
          req, $sformatf("R9 down s=%0d rnd=%0d sat=%0d", s, rnd, sat),
          {out_ovf, out_vec}, {eo, ev});
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail + 1, n_checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!out_valid && !round_mode && !sat_mode, "R10", "reset state",
          {out_valid, round_mode, sat_mode}, 3'b000);
    rst_n = 1;
    @(negedge clk);
    check(in_ready, "R1", "ready when idle", in_ready, 1'b1);

    // Downshift sweep over every mode combination and shift count
    for (int m = 0; m < 4; m++) begin
      bit rnd, sat;
      rnd = m[0]; sat = m[1];
      set_modes(rnd, sat);
      for (int s = 0; s < 64; s++) begin
        string req;
        if (s >= 48)  req = "R7";
        else if (sat) req = rnd ? "R4 R5" : "R5";
        else          req = rnd ? "R4 R6" : "R3 R6";
        fill_acc();
        run_op(1'b0, s);
        check_down(s, rnd, sat, req);
      end
    end

    // Upshift sweep
    for (int s = 0; s < 64; s++) begin
      logic [383:0] ea;
      fill_vec();
      run_op(1'b1, s);
      for (int i = 0; i < L; i++) ea[i*48 +: 48] = ref_up(b[i], s);
      check(out_valid && out_dir && out_acc == ea && out_vec == '0 && out_ovf == '0,
            "R8", $sformatf("R9 up s=%0d", s), out_acc, ea);
    end

    // Set and clear in the same cycle: clear wins
    set_modes(1'b1, 1'b1);
    pulse_cfg(1'b1, 1'b1, 1'b1, 1'b1);
    check(!round_mode && !sat_mode, "R2", "clear wins",
          {round_mode, sat_mode}, 2'b00);

    // Mode change in the same cycle as an operation uses the old mode
    fill_acc();
    @(negedge clk);
    in_dir = 0; in_shift = 6'd8; in_valid = 1; cfg_round_set = 1; cfg_sat_set = 1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 0; cfg_round_set = 0; cfg_sat_set = 0;
    check_down(8, 1'b0, 1'b0, "R2 R3");
    check(round_mode && sat_mode, "R2", "modes after same-cycle set",
          {round_mode, sat_mode}, 2'b11);

    // Stall: result must hold while out_ready is low
    fill_acc();
    @(negedge clk);
    in_dir = 0; in_shift = 6'd4; in_valid = 1; out_ready = 0;
    @(posedge clk);
    @(negedge clk);
    in_valid = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!in_ready, "R1", "not ready while stalled", in_ready, 1'b0);
    check_down(4, 1'b1, 1'b1, "R1");
    out_ready = 1;
    @(posedge clk);
    @(negedge clk);
    check(!out_valid, "R1", "drained after ready", out_valid, 1'b0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule